// File: doc/BRIEF.md
# Doorbell-Driven Transfer Ring Tracker

This block sits on the device side of a host link. It keeps the state of several circular transfer rings, one for each logical one-way channel. For each ring it holds a base address, a read index, a write index and a length. The host sets up a ring through a configuration write. It then announces new work by writing the new write index into that channel's slot of a shared doorbell array. The block reports whether each ring is empty or full. It offers the next element of a ring with pending work to a service engine, and it moves the read index forward each time the engine acknowledges an element.

An element may be one link of a longer scatter-gather descriptor. When the engine acknowledges an element, it also returns that element's chain bit. While the chain bit is set, the block keeps granting the same channel, so a multi-element descriptor is served without interruption. A one-cycle completion pulse fires after the last element, which is the one whose chain bit is clear. Channels with pending work share the engine in round-robin order, one element per grant.

Top module: `ring_tracker`

## Requirements
- R1: After reset there is no grant, no completion pulse and no error. Every ring reads empty and none reads full, because both indices reset to 0 and the length resets to all ones.
- R2: A configuration write to a supported channel loads its base, read index, write index and length, and clears its pending mark. A ring reports empty exactly when its read index equals its write index.
- R3: A ring reports full exactly when its write index, advanced by one with wrap, equals its read index. One slot therefore always stays unused.
- R4: A doorbell write to a supported channel loads that channel's write index and marks the channel pending. Indices loaded by configuration alone never cause a grant.
- R5: A doorbell write to a channel index at or above the supported count leaves every ring unchanged and sets an error flag. Only reset clears the flag.
- R6: While a grant is held, the block presents the granted channel, its read index and its base. An acknowledge advances that read index by one, wrapping from length-1 to 0.
- R7: A new grant goes to the first pending, non-empty channel found when scanning upward (with wrap) from the channel after the one granted last. The grant is registered and is held until acknowledged.
- R8: An acknowledge with the chain bit set locks arbitration to that channel. Only that channel is granted until an acknowledge with the chain bit clear.
- R9: The cycle after an acknowledge with the chain bit clear, the completion pulse is high for one cycle and carries that channel number. At no other time is it high.
- R10: A channel is never granted while its ring is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CW | Channel being configured |
| cfg_base | input | AW | Ring base address |
| cfg_len | input | PW | Ring length in elements (2 or more) |
| cfg_rp | input | PW | Initial read index |
| cfg_wp | input | PW | Initial write index |
| db_we | input | 1 | Doorbell write strobe |
| db_ch | input | CW | Doorbell slot (channel index) |
| db_wp | input | PW | New write index |
| ring_empty | output | NCH | Per-channel empty status |
| ring_full | output | NCH | Per-channel full status |
| svc_valid | output | 1 | Grant held for the service engine |
| svc_ch | output | CW | Granted channel |
| svc_idx | output | PW | Element index to service (read index) |
| svc_base | output | AW | Base address of the granted ring |
| svc_ack | input | 1 | Engine finished the offered element |
| svc_chain | input | 1 | Chain bit of the acknowledged element |
| desc_done | output | 1 | Descriptor completion pulse |
| done_ch | output | CW | Channel of the completed descriptor |
| db_err | output | 1 | Sticky error for doorbells to unsupported channels |

## Verification
The bound checker watches four properties on every cycle. A grant never points at an empty ring. A held grant keeps its channel until it is acknowledged. The locked channel is the only one granted while a chain is open. The completion pulse appears exactly one cycle after a chain-clear acknowledge and at no other time. The checker also confirms that no ring is empty and full at once and that the error flag never drops. The bench scenarios show the rest. They cover the exact round-robin order, read-index wrap at each configured length, which doorbells arm a channel and which are ignored, and the full status of rings filled to capacity. Each of these is compared with a reference model driven by a mix of random and directed doorbells, acknowledges and chain bits.

// File: rtl/ring_tracker.sv
`timescale 1ns/1ps
module ring_tracker #(
  parameter int NCH = 4,
  parameter int CW  = 8,
  parameter int PW  = 5,
  parameter int AW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CW-1:0]  cfg_ch,
  input  logic [AW-1:0]  cfg_base,
  input  logic [PW-1:0]  cfg_len,
  input  logic [PW-1:0]  cfg_rp,
  input  logic [PW-1:0]  cfg_wp,
  input  logic           db_we,
  input  logic [CW-1:0]  db_ch,
  input  logic [PW-1:0]  db_wp,
  output logic [NCH-1:0] ring_empty,
  output logic [NCH-1:0] ring_full,
  output logic           svc_valid,
  output logic [CW-1:0]  svc_ch,
  output logic [PW-1:0]  svc_idx,
  output logic [AW-1:0]  svc_base,
  input  logic           svc_ack,
  input  logic           svc_chain,
  output logic           desc_done,
  output logic [CW-1:0]  done_ch,
  output logic           db_err
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [PW-1:0] rp_q [NCH];
  logic [PW-1:0] wp_q [NCH];
  logic [PW-1:0] len_q [NCH];
  logic [AW-1:0] base_q [NCH];
  logic [NCH-1:0] armed_q, elig;

  logic          busy_q, lock_q, done_q, err_q;
  logic [IW-1:0] gch_q, last_q, lock_ch_q, dch_q, pick;
  logic          pick_vld;
  logic          ack_go;

  assign ack_go = busy_q && svc_ack;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic cfg_hit, db_hit, ack_hit;
    logic [PW-1:0] rp_nxt, wp_nxt;
    assign cfg_hit = cfg_we && (cfg_ch == CW'(i));
    assign db_hit  = db_we && (db_ch == CW'(i));
    assign ack_hit = ack_go && (gch_q == IW'(i));
    assign rp_nxt  = (rp_q[i] == len_q[i] - PW'(1)) ? '0 : rp_q[i] + PW'(1);
    assign wp_nxt  = (wp_q[i] == len_q[i] - PW'(1)) ? '0 : wp_q[i] + PW'(1);
    assign ring_empty[i] = (rp_q[i] == wp_q[i]);
    assign ring_full[i]  = (wp_nxt == rp_q[i]);
    assign elig[i] = armed_q[i] && !ring_empty[i] && (!lock_q || lock_ch_q == IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rp_q[i] <= '0; wp_q[i] <= '0; len_q[i] <= '1; base_q[i] <= '0;
        armed_q[i] <= 1'b0;
      end else if (cfg_hit) begin
        rp_q[i] <= cfg_rp; wp_q[i] <= cfg_wp; len_q[i] <= cfg_len;
        base_q[i] <= cfg_base; armed_q[i] <= 1'b0;
      end else begin
        if (ack_hit) rp_q[i] <= rp_nxt;
        if (db_hit) begin
          wp_q[i] <= db_wp;
          armed_q[i] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    pick_vld = 1'b0;
    pick = last_q;
    for (int k = 1; k <= NCH; k++) begin
      int j;
      j = (int'(last_q) + k) % NCH;
      if (!pick_vld && elig[j]) begin
        pick_vld = 1'b1;
        pick = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; gch_q <= '0; last_q <= IW'(NCH - 1);
      lock_q <= 1'b0; lock_ch_q <= '0; done_q <= 1'b0; dch_q <= '0; err_q <= 1'b0;
    end else begin
      done_q <= ack_go && !svc_chain;
      if (ack_go) dch_q <= gch_q;
      if (!busy_q && pick_vld) begin
        busy_q <= 1'b1; gch_q <= pick; last_q <= pick;
      end else if (ack_go) begin
        busy_q <= 1'b0; lock_q <= svc_chain; lock_ch_q <= gch_q;
      end
      if (db_we && db_ch >= CW'(NCH)) err_q <= 1'b1;
    end
  end

  assign svc_valid = busy_q;
  assign svc_ch    = CW'(gch_q);
  assign svc_idx   = rp_q[gch_q];
  assign svc_base  = base_q[gch_q];
  assign desc_done = done_q;
  assign done_ch   = CW'(dch_q);
  assign db_err    = err_q;
endmodule

// File: rtl/ring_tracker_chk.sv
`timescale 1ns/1ps
module ring_tracker_chk #(
  parameter int NCH = 4,
  parameter int CW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ring_empty,
  input logic [NCH-1:0] ring_full,
  input logic           svc_valid,
  input logic [CW-1:0]  svc_ch,
  input logic           svc_ack,
  input logic           svc_chain,
  input logic           desc_done,
  input logic           db_err
);
  logic          lck;
  logic [CW-1:0] lch;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lck <= 1'b0; lch <= '0;
    end else if (svc_valid && svc_ack) begin
      lck <= svc_chain; lch <= svc_ch;
    end
  end

  p_no_empty_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> !ring_empty[svc_ch]);
  p_grant_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid && !svc_ack |=> svc_valid && $stable(svc_ch));
  p_chain_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid && lck |-> svc_ch == lch);
  p_done_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid && svc_ack && !svc_chain |=> desc_done);
  p_done_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |-> $past(svc_valid && svc_ack && !svc_chain));
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    db_err |=> db_err);
  p_not_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_empty & ring_full) == '0);
endmodule

bind ring_tracker ring_tracker_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ring_empty(ring_empty), .ring_full(ring_full),
  .svc_valid(svc_valid), .svc_ch(svc_ch), .svc_ack(svc_ack), .svc_chain(svc_chain),
  .desc_done(desc_done), .db_err(db_err));

// File: tb/test_ring_tracker.sv
`timescale 1ns/1ps
module test_ring_tracker;
  localparam int NCH = 4, CW = 8, PW = 5, AW = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, db_we = 0, svc_ack = 0, svc_chain = 0;
  logic [CW-1:0] cfg_ch = 0, db_ch = 0;
  logic [AW-1:0] cfg_base = 0;
  logic [PW-1:0] cfg_len = 0, cfg_rp = 0, cfg_wp = 0, db_wp = 0;
  logic [NCH-1:0] ring_empty, ring_full;
  logic svc_valid, desc_done, db_err;
  logic [CW-1:0] svc_ch, done_ch;
  logic [PW-1:0] svc_idx;
  logic [AW-1:0] svc_base;

  always #5 clk = ~clk;

  ring_tracker #(.NCH(NCH), .CW(CW), .PW(PW), .AW(AW)) i_ring_tracker (.*);

  int n_chk = 0, n_fail = 0;
  int mrp[NCH], mwp[NCH], mlen[NCH], mbase[NCH];
  bit marm[NCH];
  bit mbusy = 0, mlock = 0, mdone = 0, merr = 0;
  int mch = 0, mlast = NCH - 1, mlch = 0, mdch = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nxt(input int p, input int l);
    return (p == l - 1) ? 0 : p + 1;
  endfunction

  task automatic compare();
    chk(svc_valid == mbusy, "R7 R10 grant valid", int'(svc_valid), int'(mbusy));
    if (mbusy && svc_valid) begin
      chk(int'(svc_ch) == mch, "R7/R8 grant channel", int'(svc_ch), mch);
      chk(int'(svc_idx) == mrp[mch], "R6 element index", int'(svc_idx), mrp[mch]);
      chk(int'(svc_base) == mbase[mch], "R6 base", int'(svc_base), mbase[mch]);
    end
    for (int i = 0; i < NCH; i++) begin
      chk(ring_empty[i] == (mrp[i] == mwp[i]), "R2 empty", int'(ring_empty[i]), int'(mrp[i] == mwp[i]));
      chk(ring_full[i] == (nxt(mwp[i], mlen[i]) == mrp[i]), "R3 full", int'(ring_full[i]),
          int'(nxt(mwp[i], mlen[i]) == mrp[i]));
    end
    chk(desc_done == mdone, "R9 done pulse", int'(desc_done), int'(mdone));
    if (mdone) chk(int'(done_ch) == mdch, "R9 done channel", int'(done_ch), mdch);
    chk(db_err == merr, "R5 error flag", int'(db_err), int'(merr));
  endtask

  task automatic tick();
    mdone = 0;
    if (mbusy && svc_ack) begin
      mrp[mch] = nxt(mrp[mch], mlen[mch]);
      mlock = svc_chain; mlch = mch; mbusy = 0;
      mdone = !svc_chain; mdch = mch;
    end else if (!mbusy) begin
      for (int k = 1; k <= NCH; k++) begin
        int j;
        j = (mlast + k) % NCH;
        if (!mbusy && marm[j] && mrp[j] != mwp[j] && (!mlock || mlch == j)) begin
          mbusy = 1; mch = j; mlast = j;
        end
      end
    end
    if (cfg_we && cfg_ch < NCH) begin
      mrp[cfg_ch] = cfg_rp; mwp[cfg_ch] = cfg_wp; mlen[cfg_ch] = cfg_len;
      mbase[cfg_ch] = cfg_base; marm[cfg_ch] = 0;
    end
    if (db_we) begin
      if (db_ch < NCH) begin mwp[db_ch] = db_wp; marm[db_ch] = 1; end
      else merr = 1;
    end
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0; db_we = 0; svc_ack = 0; svc_chain = 0;
    compare();
  endtask

  task automatic do_cfg(input int ch, input int len, input int rp, input int wp, input int base);
    cfg_we = 1; cfg_ch = CW'(ch); cfg_len = PW'(len); cfg_rp = PW'(rp);
    cfg_wp = PW'(wp); cfg_base = AW'(base);
    tick();
  endtask

  task automatic ring_db(input int ch, input int wp);
    db_we = 1; db_ch = CW'(ch); db_wp = PW'(wp);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NCH; i++) begin
      mrp[i] = 0; mwp[i] = 0; mlen[i] = 31; mbase[i] = 0; marm[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(svc_valid == 0, "R1 no grant", int'(svc_valid), 0);
    chk(ring_empty == '1, "R1 all empty", int'(ring_empty), (1 << NCH) - 1);
    chk(ring_full == '0, "R1 none full", int'(ring_full), 0);
    chk(desc_done == 0 && db_err == 0, "R1 no pulse or error", int'(desc_done | db_err), 0);

    // R2 R3 R4: configuration alone, including a full ring, gives no grant
    do_cfg(0, 2, 1, 1, 16'h1000);
    do_cfg(1, 7, 3, 3, 16'h2000);
    do_cfg(2, 12, 10, 10, 16'h3000);
    do_cfg(3, 5, 0, 4, 16'h4000);
    chk(ring_full[3] == 1, "R3 ring full after cfg", int'(ring_full[3]), 1);
    repeat (4) tick();
    chk(svc_valid == 0, "R4 no grant without doorbell", int'(svc_valid), 0);

    // R5 unsupported doorbell leaves rings untouched
    ring_db(NCH + 9, 2);
    chk(db_err == 1, "R5 error raised", int'(db_err), 1);
    chk(ring_empty[0] == 1 && svc_valid == 0, "R5 no effect", int'(svc_valid), 0);

    // R7 R8 directed: three channels pending, channel 3 locked by a chain
    ring_db(3, 4);
    ring_db(1, 6);
    ring_db(0, 0);
    tick();
    chk(int'(svc_ch) == 3 && svc_valid, "R7 first grant", int'(svc_ch), 3);
    svc_ack = 1; svc_chain = 1; tick();
    tick();
    chk(int'(svc_ch) == 3 && svc_valid, "R8 chain keeps channel", int'(svc_ch), 3);
    svc_ack = 1; svc_chain = 0; tick();
    chk(desc_done == 1 && int'(done_ch) == 3, "R9 done after chain end", int'(done_ch), 3);
    tick();
    chk(int'(svc_ch) == 0 && svc_valid, "R7 next in rotation", int'(svc_ch), 0);
    svc_ack = 1; tick();
    tick();
    chk(int'(svc_ch) == 1, "R7 rotation continues", int'(svc_ch), 1);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      if (mbusy && ($urandom % 3 != 0)) begin
        svc_ack = 1; svc_chain = ($urandom % 3 == 0);
      end
      if ($urandom % 4 == 0) begin
        int ch;
        db_we = 1;
        if ($urandom % 10 == 0) begin
          ch = NCH + int'($urandom % (256 - NCH));
          db_ch = CW'(ch); db_wp = PW'($urandom);
        end else begin
          int occ, fr, k;
          ch = int'($urandom % NCH);
          occ = (mwp[ch] - mrp[ch] + mlen[ch]) % mlen[ch];
          fr = mlen[ch] - 1 - occ;
          k = int'($urandom % (fr + 1));
          db_ch = CW'(ch); db_wp = PW'((mwp[ch] + k) % mlen[ch]);
        end
      end
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule